// File: doc/BRIEF.md
# Register-Mapped UART with Line Control

This block is an asynchronous serial port driven through a small register file. Software writes characters into a transmit queue through the data register and pops received characters from a receive queue through the same address. Each received character carries three status bits (framing, parity, overrun), and these become visible in a separate status register after the data read. A divisor, a line-format register and a port enable together set the serial format. The port enable gates the baud generator, both serial state machines and both interrupt lines.

The transmitter is a state machine with the states TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP and TX_BREAK. TX_IDLE moves to TX_START on a baud tick when a character is queued, or to TX_BREAK when break is set. TX_START moves to TX_DATA after one bit time. TX_DATA moves to TX_PAR, or to TX_STOP when parity is off, after the last data bit. TX_PAR moves to TX_STOP. TX_STOP returns to TX_IDLE after one or two stop bits. TX_BREAK returns to TX_IDLE when break clears.

The receiver has the states RX_IDLE, RX_START, RX_DATA, RX_PAR and RX_STOP. RX_IDLE moves to RX_START on a low line. RX_START returns to RX_IDLE if the line is high at mid-bit, and otherwise moves to RX_DATA. RX_DATA moves to RX_PAR or RX_STOP after the last bit. RX_PAR moves to RX_STOP. RX_STOP stores the character and returns to RX_IDLE.

Top module: `uart_linectl`

Register addresses: 0 data, 1 receive status, 2 divisor bits 7:0, 3 divisor bits 11:8, 4 line format, 5 control, 6 flags.

## Requirements
- R1: After reset the flag register reads 0x10 (only receive-empty set), both interrupts are low and `txd` is high.
- R2: While control bit 0 is clear, `txd` stays high, both interrupts stay low and no queued character is sent; setting the bit starts transmission of queued characters.
- R3: A frame is a low start bit, the data bits LSB first, an optional parity bit and high stop bits. Each bit lasts 16*(divisor+1) clocks. Line-format bits 6:5 choose 5, 6, 7 or 8 data bits for 00, 01, 10 and 11.
- R4: Line-format bit 1 enables parity and bit 2 selects even parity (odd when clear). A received parity mismatch sets status bit 1.
- R5: Line-format bit 3 selects two stop bits. A received character whose first stop bit samples low sets status bit 0.
- R6: While line-format bit 0 is set and the port is enabled, `txd` is held low, and no new character starts.
- R7: With line-format bit 4 set, each queue holds 16 characters in order. Flag bit 5 (transmit full) sets on the 16th write.
- R8: With line-format bit 4 clear, each queue holds one character, and flag bit 5 sets after a single write.
- R9: A character that arrives while the receive queue is full is dropped, and status bit 2 (overrun) is set on the last character already held.
- R10: A low pulse that is no longer low at the middle of the start bit produces no character, and the receiver stays ready for the next frame.
- R11: `irq_rx` is high while the port is enabled and the receive queue is not empty. `irq_tx` is high while the port is enabled and the transmit queue is not full.
- R12: Flag bit 3 is set while the transmit queue holds a character or a frame is still being shifted out.
- R13: The status register keeps the three bits of the most recently read character until the next data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of address 0 pops a character) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq_rx | output | 1 | Receive data available |
| irq_tx | output | 1 | Room in the transmit queue |

## Verification
A state machine stuck outside its idle state shows within one bit time: `txd` stays low or the busy flag never clears. A miscounted bit index shifts every received character, and the first loopback read shows it. A queue pointer or count error shows in the flags and interrupts on the write or read that crosses the capacity boundary. A wrong overrun marking shows in the status read that directly follows the first data read after the drop.

// File: rtl/uart_lc_pkg.sv
package uart_lc_pkg;
    localparam logic [2:0] A_DATA  = 3'd0;
    localparam logic [2:0] A_RXST  = 3'd1;
    localparam logic [2:0] A_DIVLO = 3'd2;
    localparam logic [2:0] A_DIVHI = 3'd3;
    localparam logic [2:0] A_LINE  = 3'd4;
    localparam logic [2:0] A_CTRL  = 3'd5;
    localparam logic [2:0] A_FLAG  = 3'd6;

    // line-format register, MSB first: bits 6:5 width, 4 queues, 3 two stop, 2 even, 1 parity, 0 break
    typedef struct packed {
        logic [1:0] wlen;
        logic       queue_on;
        logic       two_stop;
        logic       par_even;
        logic       par_on;
        logic       brk;
    } line_cfg_t;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP, TX_BREAK} tx_state_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_e;

    function automatic logic [3:0] data_bits(input logic [1:0] wlen);
        return 4'd5 + {2'b00, wlen};
    endfunction
endpackage

// File: rtl/uart_lc_fifo.sv
module uart_lc_fifo #(
    parameter int W        = 8,
    parameter int DEPTH    = 16,
    parameter int MARK_BIT = 0,
    localparam int AW      = $clog2(DEPTH),
    localparam int CW      = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          one_slot,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic          mark,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = one_slot ? (count != '0) : (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
        else if (mark && !empty) mem[wp - 1'b1][MARK_BIT] <= 1'b1;
    end
endmodule

// File: rtl/uart_lc_tx.sv
module uart_lc_tx
    import uart_lc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  line_cfg_t  cfg,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    output logic       q_pop,
    output logic       tx_idle,
    output logic       txd
);
    tx_state_e  state;
    logic [3:0] cnt;
    logic [2:0] idx;
    logic [7:0] shreg;
    logic       par_bit, second;
    logic [3:0] nb;
    logic [7:0] masked;

    assign nb     = data_bits(cfg.wlen);
    assign masked = q_data & (8'hFF >> (4'd8 - nb));
    assign q_pop  = en && tick && (state == TX_IDLE) && !cfg.brk && !q_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE; cnt <= '0; idx <= '0;
            shreg <= '0; par_bit <= 1'b0; second <= 1'b0;
        end else if (!en) begin
            state <= TX_IDLE; cnt <= '0;
        end else if (tick) begin
            unique case (state)
                TX_IDLE: begin
                    cnt <= '0;
                    if (cfg.brk) state <= TX_BREAK;
                    else if (!q_empty) begin
                        shreg   <= masked;
                        par_bit <= (^masked) ^ !cfg.par_even;
                        state   <= TX_START;
                    end
                end
                TX_BREAK: if (!cfg.brk) state <= TX_IDLE;
                TX_START: begin
                    cnt <= cnt + 4'd1;
                    if (cnt == 4'd15) begin state <= TX_DATA; idx <= '0; end
                end
                TX_DATA: begin
                    cnt <= cnt + 4'd1;
                    if (cnt == 4'd15) begin
                        shreg <= shreg >> 1;
                        idx   <= idx + 3'd1;
                        if ({1'b0, idx} == nb - 4'd1) begin
                            state  <= cfg.par_on ? TX_PAR : TX_STOP;
                            second <= 1'b0;
                        end
                    end
                end
                TX_PAR: begin
                    cnt <= cnt + 4'd1;
                    if (cnt == 4'd15) state <= TX_STOP;
                end
                TX_STOP: begin
                    cnt <= cnt + 4'd1;
                    if (cnt == 4'd15) begin
                        if (cfg.two_stop && !second) second <= 1'b1;
                        else state <= TX_IDLE;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        tx_idle = (state == TX_IDLE);
        if (en && cfg.brk) txd = 1'b0;
        else begin
            unique case (state)
                TX_START: txd = 1'b0;
                TX_DATA:  txd = shreg[0];
                TX_PAR:   txd = par_bit;
                default:  txd = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/uart_lc_rx.sv
module uart_lc_rx
    import uart_lc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        tick,
    input  line_cfg_t   cfg,
    input  logic        rxd,
    output logic        push,
    output logic [10:0] entry
);
    rx_state_e  state;
    logic [1:0] sync;
    logic       rx_s, par_seen;
    logic [3:0] cnt;
    logic [2:0] idx;
    logic [7:0] shreg, chr;
    logic [3:0] nb;
    logic       par_err;

    assign rx_s    = sync[1];
    assign nb      = data_bits(cfg.wlen);
    assign chr     = shreg >> (4'd8 - nb);
    assign par_err = cfg.par_on && (par_seen != ((^chr) ^ !cfg.par_even));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync <= 2'b11; state <= RX_IDLE; cnt <= '0; idx <= '0;
            shreg <= '0; par_seen <= 1'b0; push <= 1'b0; entry <= '0;
        end else begin
            sync <= {sync[0], rxd};
            push <= 1'b0;
            if (!en) state <= RX_IDLE;
            else if (state == RX_IDLE) begin
                cnt <= '0;
                if (!rx_s) state <= RX_START;
            end else if (tick) begin
                cnt <= cnt + 4'd1;
                unique case (state)
                    RX_START: if (cnt == 4'd7) begin
                        cnt <= '0; idx <= '0;
                        state <= rx_s ? RX_IDLE : RX_DATA;
                    end
                    RX_DATA: if (cnt == 4'd15) begin
                        shreg <= {rx_s, shreg[7:1]};
                        idx   <= idx + 3'd1;
                        if ({1'b0, idx} == nb - 4'd1) state <= cfg.par_on ? RX_PAR : RX_STOP;
                    end
                    RX_PAR: if (cnt == 4'd15) begin
                        par_seen <= rx_s;
                        state    <= RX_STOP;
                    end
                    RX_STOP: if (cnt == 4'd15) begin
                        push  <= 1'b1;
                        entry <= {1'b0, par_err, !rx_s, chr};
                        state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_linectl.sv
module uart_linectl
    import uart_lc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV_W = 12,
    localparam int HI_W = DIV_W - 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq_rx,
    output logic       irq_tx
);
    line_cfg_t         line_q;
    logic [7:0]        div_lo_q;
    logic [HI_W-1:0]   div_hi_q;
    logic              en_q;
    logic [2:0]        stat_q;
    logic [DIV_W-1:0]  baud_cnt;
    logic              tick, brk_on, one_slot;
    logic              tx_push, tx_pop, tx_empty, tx_full, tx_idle;
    logic [7:0]        tx_dout;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              rx_push, rx_pop, rx_empty, rx_full;
    logic [10:0]       rx_din, rx_dout;

    assign brk_on   = line_q.brk;
    assign one_slot = !line_q.queue_on;
    assign tick     = en_q && (baud_cnt == {div_hi_q, div_lo_q});
    assign tx_push  = wr_en && (addr == A_DATA);
    assign rx_pop   = rd_en && (addr == A_DATA);
    assign irq_rx   = en_q && !rx_empty;
    assign irq_tx   = en_q && !tx_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0; div_lo_q <= '0; div_hi_q <= '0;
            en_q <= 1'b0; stat_q <= '0; baud_cnt <= '0;
        end else begin
            baud_cnt <= (!en_q || tick) ? '0 : baud_cnt + 1'b1;
            if (wr_en) begin
                unique case (addr)
                    A_DIVLO: div_lo_q <= wdata;
                    A_DIVHI: div_hi_q <= wdata[HI_W-1:0];
                    A_LINE:  line_q   <= wdata[6:0];
                    A_CTRL:  en_q     <= wdata[0];
                    default: ;
                endcase
            end
            if (rx_pop && !rx_empty) stat_q <= rx_dout[10:8];
        end
    end

    uart_lc_fifo #(.W(8), .DEPTH(DEPTH), .MARK_BIT(0)) u_txq (
        .clk(clk), .rst_n(rst_n), .one_slot(one_slot), .push(tx_push), .din(wdata),
        .pop(tx_pop), .mark(1'b0), .dout(tx_dout), .empty(tx_empty), .full(tx_full),
        .count(tx_cnt));

    uart_lc_fifo #(.W(11), .DEPTH(DEPTH), .MARK_BIT(10)) u_rxq (
        .clk(clk), .rst_n(rst_n), .one_slot(one_slot), .push(rx_push), .din(rx_din),
        .pop(rx_pop), .mark(rx_push && rx_full), .dout(rx_dout), .empty(rx_empty),
        .full(rx_full), .count(rx_cnt));

    uart_lc_tx u_tx (
        .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick), .cfg(line_q),
        .q_empty(tx_empty), .q_data(tx_dout), .q_pop(tx_pop), .tx_idle(tx_idle), .txd(txd));

    uart_lc_rx u_rx (
        .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick), .cfg(line_q),
        .rxd(rxd), .push(rx_push), .entry(rx_din));

    always_comb begin
        unique case (addr)
            A_DATA:  rdata = rx_empty ? 8'h00 : rx_dout[7:0];
            A_RXST:  rdata = {5'b0, stat_q};
            A_DIVLO: rdata = div_lo_q;
            A_DIVHI: rdata = 8'(div_hi_q);
            A_LINE:  rdata = {1'b0, line_q};
            A_CTRL:  rdata = {7'b0, en_q};
            A_FLAG:  rdata = {2'b0, tx_full, rx_empty, !tx_empty || !tx_idle, 3'b0};
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/uart_lc_chk.sv
module uart_lc_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          brk,
    input logic          txd,
    input logic          tx_idle,
    input logic          irq_tx,
    input logic          irq_rx,
    input logic          tx_full,
    input logic          rx_empty,
    input logic          one_slot,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count
);
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (txd && !irq_tx && !irq_rx));  // R2
    AST_IDLE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !brk && tx_idle) |-> txd);  // R3
    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en && brk) |-> !txd);  // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));  // R7
    AST_ONE_SLOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (one_slot && tx_count != '0) |-> tx_full);  // R8
    AST_IRQ_TX_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> !tx_full);  // R11
    AST_IRQ_RX_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rx) |-> !rx_empty);  // R11
endmodule

bind uart_linectl uart_lc_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_q), .brk(brk_on), .txd(txd), .tx_idle(tx_idle),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .tx_full(tx_full), .rx_empty(rx_empty),
    .one_slot(one_slot), .tx_count(tx_cnt), .rx_count(rx_cnt));

// File: tb/test_uart_linectl.sv
module test_uart_linectl;
    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, rdata, v;
    logic txd, rxd, irq_rx, irq_tx;
    logic loop_on = 1'b1, drv_rx = 1'b1;
    int checks = 0, errors = 0;
    int cyc = 0;

    // {line format, byte sent, byte expected}, divisor 0, loopback
    localparam logic [23:0] VEC [6] = '{
        24'h60_A5_A5,   // 8N1
        24'h40_FF_7F,   // 7N1
        24'h26_3C_3C,   // 6E1
        24'h0A_5B_1B,   // 5O2
        24'h6E_81_81,   // 8E2
        24'h72_00_00    // 8O1 queues on
    };

    assign rxd = loop_on ? txd : drv_rx;
    always #4 clk = ~clk;

    uart_linectl i_uart_linectl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq_rx(irq_rx), .irq_tx(irq_tx));

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                summary();
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic cfg(input logic [7:0] line, input logic [11:0] div);
        wr(3'd5, 8'h00); wr(3'd2, div[7:0]); wr(3'd3, {4'h0, div[11:8]});
        wr(3'd4, line); wr(3'd5, 8'h01);
    endtask

    task automatic wait_rx(input int maxc);
        for (int i = 0; i < maxc && !irq_rx; i++) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input bit par_on,
                        input bit even, input bit flip, input bit stop_ok);
        logic [7:0] m;
        m = d & (8'hFF >> (8 - nb));
        drv_rx = 1'b0; repeat (16) @(negedge clk);
        for (int i = 0; i < nb; i++) begin drv_rx = m[i]; repeat (16) @(negedge clk); end
        if (par_on) begin drv_rx = (^m) ^ !even ^ flip; repeat (16) @(negedge clk); end
        if (stop_ok) begin drv_rx = 1'b1; repeat (16) @(negedge clk); end
        else begin drv_rx = 1'b0; repeat (12) @(negedge clk); drv_rx = 1'b1; end
        repeat (32) @(negedge clk);
    endtask

    initial begin
        int lows;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd6, v); check("R1 flags", v, 8'h10);
        check("R1 irq_rx", irq_rx, 1'b0); check("R1 irq_tx", irq_tx, 1'b0);
        check("R1 txd", txd, 1'b1);

        // R2 disabled port holds a queued byte; R8 single slot full; R12 busy
        wr(3'd4, 8'h60); wr(3'd0, 8'h3C);
        lows = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (!txd) lows++; end
        check("R2 no send while disabled", lows, 0);
        check("R2 irq_tx low while disabled", irq_tx, 1'b0);
        rd(3'd6, v); check("R8 R12 flags one slot", v, 8'h38);
        wr(3'd5, 8'h01);
        wait_rx(400);
        rd(3'd0, v); check("R2 sent after enable", v, 8'h3C);
        rd(3'd1, v); check("R13 clean status", v, 8'h00);
        repeat (30) @(negedge clk);
        rd(3'd6, v); check("R12 busy cleared", v, 8'h10);

        // R3 bit time with divisor 1
        cfg(8'h60, 12'd1); wr(3'd0, 8'hFF);
        for (int i = 0; i < 200 && txd; i++) @(negedge clk);
        lows = 0;
        for (int i = 0; i < 200 && !txd; i++) begin lows++; @(negedge clk); end
        check("R3 start bit length", lows, 32);
        wait_rx(800);
        rd(3'd0, v); check("R3 byte at divisor 1", v, 8'hFF);
        repeat (60) @(negedge clk);

        // R3 R4 R5 format table
        foreach (VEC[k]) begin
            cfg(VEC[k][23:16], 12'd0);
            wr(3'd0, VEC[k][15:8]);
            wait_rx(400);
            rd(3'd0, v); check($sformatf("R3 R5 table %0d data", k), v, VEC[k][7:0]);
            rd(3'd1, v); check($sformatf("R4 table %0d status", k), v, 8'h00);
            repeat (40) @(negedge clk);
        end

        // R7 sixteen-deep queues, R11 interrupts
        wr(3'd5, 8'h00); wr(3'd4, 8'h70);
        for (int i = 1; i <= 15; i++) wr(3'd0, 8'(i));
        rd(3'd6, v); check("R7 not full at 15", v, 8'h18);
        wr(3'd0, 8'd16);
        rd(3'd6, v); check("R7 full at 16", v, 8'h38);
        wr(3'd5, 8'h01);
        repeat (2800) @(negedge clk);
        check("R11 irq_rx with data", irq_rx, 1'b1);
        check("R11 irq_tx with room", irq_tx, 1'b1);
        for (int i = 1; i <= 16; i++) begin
            rd(3'd0, v); check($sformatf("R7 order %0d", i), v, 8'(i));
        end
        rd(3'd6, v); check("R7 drained", v, 8'h10);
        check("R11 irq_rx when empty", irq_rx, 1'b0);

        // R9 overrun in single-slot mode
        loop_on = 1'b0;
        cfg(8'h60, 12'd0);
        send(8'h11, 8, 0, 0, 0, 1);
        send(8'h22, 8, 0, 0, 0, 1);
        rd(3'd0, v); check("R9 kept data", v, 8'h11);
        rd(3'd1, v); check("R9 overrun bit", v, 8'h04);
        rd(3'd1, v); check("R13 status persists", v, 8'h04);
        rd(3'd6, v); check("R9 second dropped", v, 8'h10);

        // R4 parity error
        cfg(8'h66, 12'd0);
        send(8'h03, 8, 1, 1, 1, 1);
        rd(3'd0, v); check("R4 data", v, 8'h03);
        rd(3'd1, v); check("R4 parity bit", v, 8'h02);

        // R5 framing error
        cfg(8'h60, 12'd0);
        send(8'h55, 8, 0, 0, 0, 0);
        rd(3'd0, v); check("R5 data", v, 8'h55);
        rd(3'd1, v); check("R5 framing bit", v, 8'h01);
        repeat (200) @(negedge clk);
        rd(3'd6, v); check("R10 no extra char after bad stop", v, 8'h10);

        // R10 glitch rejection
        drv_rx = 1'b0; repeat (4) @(negedge clk); drv_rx = 1'b1;
        repeat (300) @(negedge clk);
        check("R10 glitch ignored", irq_rx, 1'b0);
        send(8'h5A, 8, 0, 0, 0, 1);
        rd(3'd0, v); check("R10 receiver recovers", v, 8'h5A);

        // R6 break
        cfg(8'h61, 12'd0);
        repeat (3) @(negedge clk);
        lows = 0;
        for (int i = 0; i < 200; i++) begin @(negedge clk); if (txd) lows++; end
        check("R6 line held low", lows, 0);
        wr(3'd4, 8'h60);
        repeat (3) @(negedge clk);
        check("R6 released", txd, 1'b1);

        summary();
    end
endmodule